// File: doc/BRIEF.md
# Receive Descriptor List Walker

This block keeps the address of the receive descriptor currently in use and steps it through a chain of descriptors held in system memory. Software loads a starting address through a small register port while the walker is parked, then pulses a receive-enable strobe. The walker issues a single-word memory read at the descriptor's base address to obtain its link word. When the link points onward, it reports the descriptor as ready for DMA. When the receive path signals that the descriptor has been used up, it moves to the linked address and fetches the next link.

A zero link marks the end of the chain. The walker then parks on the last descriptor and does not move. Each later strobe makes it fetch that same link word again, so descriptors that software appends to the tail are picked up. If the strobe arrives while the pointer holds zero, the walker enters a silent mode: the receive path keeps buffering frames in its FIFO but performs no DMA. Loading a non-zero address and strobing again leaves silent mode so the buffered frames can be drained.

Top module: `rx_desc_walker`

## Requirements
- R1: After a hard reset (rst_n low) or a synchronous soft reset (soft_rst_i high at a clock edge), the pointer reads 0, and dma_ready_o, silent_o, wr_err_o and mem_req_o are all 0.
- R2: Bits 1:0 of the pointer always read 0; the two low bits of written data are dropped.
- R3: A write on the register port in the parked or silent state loads the pointer, and reg_rdata_o shows the new value from the next cycle.
- R4: A write while fetching, ready or waiting at a NULL link leaves the pointer unchanged and sets wr_err_o, which stays 1 until a reset.
- R5: A strobe in the parked state with a non-zero pointer raises mem_req_o with mem_addr_o equal to the pointer, both held until mem_rsp_valid_i is seen.
- R6: A non-zero link word puts the walker in the ready state (dma_ready_o = 1); a consumed pulse there loads the link word into the pointer and starts the next link fetch.
- R7: A link word of 0 leaves the pointer on the current descriptor with dma_ready_o = 0, and consumed pulses in that state have no effect on the pointer.
- R8: A strobe while waiting at a NULL link fetches the same descriptor's link word again, so a link appended in memory in the meantime makes the walker ready.
- R9: A strobe with the pointer at 0 enters silent mode: silent_o = 1, dma_ready_o = 0, and no memory read is issued.
- R10: A write of a non-zero address in silent mode followed by a strobe clears silent_o and fetches the link at that address.
- R11: A strobe while fetching or ready has no effect on the pointer or the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset |
| reg_wr_i | input | 1 | Pointer write strobe |
| reg_wdata_i | input | 32 | Pointer write data |
| reg_rdata_o | output | 32 | Current pointer value |
| rx_en_i | input | 1 | Receive-enable strobe |
| consumed_i | input | 1 | Current descriptor has been used up |
| mem_req_o | output | 1 | Link-word read request |
| mem_addr_o | output | 32 | Read address (descriptor base) |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data (link word) |
| dma_ready_o | output | 1 | Descriptor with known successor ready for DMA |
| silent_o | output | 1 | Buffer-only receive mode |
| wr_err_o | output | 1 | Sticky flag: write refused while walking |

## Verification
The assertions assume that memory answers a request with exactly one mem_rsp_valid_i pulse while mem_req_o is high and never answers unasked. They also assume that consumed_i is raised only when the receive path holds a ready descriptor. The bench's memory model waits a fixed number of cycles after it sees a request and then gives a single pulse. Each strobe, write and consumed input is a one-cycle pulse followed by enough idle cycles for a fetch to finish, so no two events overlap unless a test intends it.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;

  parameter int unsigned PTR_W = 32;
  localparam int unsigned ALIGN_BITS = 2;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_WAIT   = 3'd3,
    ST_SILENT = 3'd4
  } walk_st_e;

  // Clear the word-alignment bits of an address.
  function automatic logic [PTR_W-1:0] word_align(input logic [PTR_W-1:0] a);
    return {a[PTR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  endfunction

  // A link word is the end of the chain when its aligned value is zero.
  function automatic logic link_is_end(input logic [PTR_W-1:0] a);
    return (word_align(a) == '0);
  endfunction

  // Software may load the pointer only while the walker is parked.
  function automatic logic sw_write_ok(input walk_st_e s);
    return (s == ST_IDLE) || (s == ST_SILENT);
  endfunction

endpackage

// File: rtl/rxdw_ptr_reg.sv
module rxdw_ptr_reg
  import rxdw_pkg::*;
#(
  parameter int unsigned W = PTR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  walk_st_e     st,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_data,
  input  logic         adv,
  input  logic [W-1:0] link,
  output logic [W-1:0] ptr_q,
  output logic         err_q
);

  logic load_sw, wr_reject, load_link;

  assign load_sw   = sw_wr && sw_write_ok(st);
  assign wr_reject = sw_wr && !sw_write_ok(st);
  assign load_link = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      err_q <= 1'b0;
    end else if (soft_rst) begin
      ptr_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (load_sw)        ptr_q <= word_align(sw_data);
      else if (load_link) ptr_q <= word_align(link);
      if (wr_reject)      err_q <= 1'b1;
    end
  end

  // R2
  ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    ptr_q[1:0] == 2'b00);

  // R4
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (wr_reject && !load_link) |=> ($stable(ptr_q) && err_q));

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    err_q |=> err_q);

endmodule

// File: rtl/rxdw_link_fetch.sv
module rxdw_link_fetch
  import rxdw_pkg::*;
#(
  parameter int unsigned W = PTR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         in_fetch,
  input  logic [W-1:0] ptr,
  input  logic         rsp_valid,
  input  logic [W-1:0] rsp_data,
  output logic         mem_req,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] link_q,
  output logic         fetch_done,
  output logic         link_null
);

  assign mem_req    = in_fetch;
  assign mem_addr   = ptr;
  assign fetch_done = in_fetch && rsp_valid;
  assign link_null  = link_is_end(rsp_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          link_q <= '0;
    else if (soft_rst)   link_q <= '0;
    else if (fetch_done) link_q <= word_align(rsp_data);
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (mem_req && !rsp_valid) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: rtl/rxdw_fsm.sv
module rxdw_fsm
  import rxdw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  logic     rx_en,
  input  logic     ptr_zero,
  input  logic     fetch_done,
  input  logic     link_null,
  input  logic     consumed,
  output walk_st_e st,
  output logic     adv
);

  walk_st_e st_nx;

  assign adv = (st == ST_ACTIVE) && consumed;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:   if (rx_en) st_nx = ptr_zero ? ST_SILENT : ST_FETCH;
      ST_FETCH:  if (fetch_done) st_nx = link_null ? ST_WAIT : ST_ACTIVE;
      ST_ACTIVE: if (consumed) st_nx = ST_FETCH;
      ST_WAIT:   if (rx_en) st_nx = ST_FETCH;
      ST_SILENT: if (rx_en && !ptr_zero) st_nx = ST_FETCH;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st <= ST_IDLE;
    else if (soft_rst) st <= ST_IDLE;
    else               st <= st_nx;
  end

  // R9
  silent_entry_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (st == ST_IDLE && rx_en && ptr_zero) |=> (st == ST_SILENT));

  // R8
  reread_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (st == ST_WAIT && rx_en) |=> (st == ST_FETCH));

  // R11
  strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (st == ST_ACTIVE && rx_en && !consumed) |=> (st == ST_ACTIVE));

endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker
  import rxdw_pkg::*;
#(
  parameter int unsigned W = PTR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst_i,
  input  logic         reg_wr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  input  logic         rx_en_i,
  input  logic         consumed_i,
  output logic         mem_req_o,
  output logic [W-1:0] mem_addr_o,
  input  logic         mem_rsp_valid_i,
  input  logic [W-1:0] mem_rsp_data_i,
  output logic         dma_ready_o,
  output logic         silent_o,
  output logic         wr_err_o
);

  walk_st_e     st;
  logic         adv, fetch_done, link_null, ptr_zero;
  logic [W-1:0] ptr_q, link_q;

  assign ptr_zero = (ptr_q == '0);

  rxdw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_i),
    .rx_en(rx_en_i), .ptr_zero(ptr_zero), .fetch_done(fetch_done),
    .link_null(link_null), .consumed(consumed_i), .st(st), .adv(adv)
  );

  rxdw_ptr_reg #(.W(W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_i), .st(st),
    .sw_wr(reg_wr_i), .sw_data(reg_wdata_i), .adv(adv), .link(link_q),
    .ptr_q(ptr_q), .err_q(wr_err_o)
  );

  rxdw_link_fetch #(.W(W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_i),
    .in_fetch(st == ST_FETCH), .ptr(ptr_q),
    .rsp_valid(mem_rsp_valid_i), .rsp_data(mem_rsp_data_i),
    .mem_req(mem_req_o), .mem_addr(mem_addr_o), .link_q(link_q),
    .fetch_done(fetch_done), .link_null(link_null)
  );

  assign reg_rdata_o = ptr_q;
  assign dma_ready_o = (st == ST_ACTIVE);
  assign silent_o    = (st == ST_SILENT);

  // R6
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
    (dma_ready_o && consumed_i && !reg_wr_i) |=> (ptr_q == $past(link_q) && mem_req_o));

  // R7
  hold_null_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
    (st == ST_WAIT) |=> $stable(ptr_q));

  // R9
  silent_nodma_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
    silent_o |-> (!mem_req_o && !dma_ready_o));

endmodule

// File: tb/rx_desc_walker_bench.sv
module rx_desc_walker_bench;

  localparam int OP_WR = 0, OP_STB = 1, OP_CON = 2, OP_APP = 3, OP_SRST = 4;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] data;
    logic [31:0] ptr;
    logic        dma;
    logic        sil;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [0:NV-1] = '{
    {3'd0, 32'h10, 32'h10, 1'b0, 1'b0, 1'b0, 4'd3},
    {3'd1, 32'h00, 32'h10, 1'b1, 1'b0, 1'b0, 4'd6},
    {3'd2, 32'h00, 32'h20, 1'b1, 1'b0, 1'b0, 4'd6},
    {3'd0, 32'h99, 32'h20, 1'b1, 1'b0, 1'b1, 4'd4},
    {3'd2, 32'h00, 32'h30, 1'b0, 1'b0, 1'b1, 4'd7},
    {3'd2, 32'h00, 32'h30, 1'b0, 1'b0, 1'b1, 4'd7},
    {3'd1, 32'h00, 32'h30, 1'b0, 1'b0, 1'b1, 4'd8},
    {3'd3, 32'h40, 32'h30, 1'b0, 1'b0, 1'b1, 4'd8},
    {3'd1, 32'h00, 32'h30, 1'b1, 1'b0, 1'b1, 4'd8},
    {3'd2, 32'h00, 32'h40, 1'b0, 1'b0, 1'b1, 4'd6},
    {3'd4, 32'h00, 32'h00, 1'b0, 1'b0, 1'b0, 4'd1},
    {3'd1, 32'h00, 32'h00, 1'b0, 1'b1, 1'b0, 4'd9},
    {3'd0, 32'h13, 32'h10, 1'b0, 1'b1, 1'b0, 4'd2},
    {3'd1, 32'h00, 32'h10, 1'b1, 1'b0, 1'b0, 4'd10}
  };

  logic        clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic        reg_wr = 1'b0, rx_en = 1'b0, consumed = 1'b0;
  logic [31:0] wdata = '0;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic [31:0] rdata, mem_addr;
  logic        mem_req, dma_ready, silent, wr_err;

  logic [31:0] mem [0:63];
  int          lat = 0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  rx_desc_walker u_rx_desc_walker (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst),
    .reg_wr_i(reg_wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rx_en_i(rx_en), .consumed_i(consumed),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .dma_ready_o(dma_ready), .silent_o(silent), .wr_err_o(wr_err)
  );

  // Memory model: one response pulse three cycles after a request is seen.
  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (mem_req && !rsp_valid) begin
      if (lat == 2) begin
        rsp_valid <= 1'b1;
        rsp_data  <= mem[mem_addr[7:2]];
        lat       <= 0;
      end else lat <= lat + 1;
    end else lat <= 0;
  end

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      4'd10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    case (v.op)
      OP_WR:   begin reg_wr = 1'b1; wdata = v.data; end
      OP_STB:  rx_en = 1'b1;
      OP_CON:  consumed = 1'b1;
      OP_APP:  mem[12] = v.data;
      default: soft_rst = 1'b1;
    endcase
    @(negedge clk);
    reg_wr = 1'b0; rx_en = 1'b0; consumed = 1'b0; soft_rst = 1'b0;
    idle(8);
  endtask

  task automatic check_state(input string r, input logic [31:0] p,
                             input logic d, input logic s, input logic e);
    chk(r, "pointer", rdata, p);
    chk(r, "dma_ready", {31'b0, dma_ready}, {31'b0, d});
    chk(r, "silent", {31'b0, silent}, {31'b0, s});
    chk(r, "wr_err", {31'b0, wr_err}, {31'b0, e});
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[4] = 32'h20;
    mem[8] = 32'h30;
    idle(3);
    // R1: hard reset state
    check_state("R1", 32'h0, 1'b0, 1'b0, 1'b0);
    chk("R1", "mem_req", {31'b0, mem_req}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k]);
      check_state(tag(VEC[k].req), VEC[k].ptr, VEC[k].dma, VEC[k].sil, VEC[k].err);
    end

    // R11: strobe while ready changes nothing
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk); rx_en = 1'b0;
    chk("R11", "mem_req", {31'b0, mem_req}, 32'h0);
    idle(6);
    check_state("R11", 32'h10, 1'b1, 1'b0, 1'b0);

    // R5: consumed starts a read at the new pointer, held until answered
    @(negedge clk); consumed = 1'b1;
    @(negedge clk); consumed = 1'b0;
    chk("R5", "mem_req", {31'b0, mem_req}, 32'h1);
    chk("R5", "mem_addr", mem_addr, 32'h20);
    @(negedge clk);
    chk("R5", "mem_req held", {31'b0, mem_req}, 32'h1);
    chk("R5", "mem_addr held", mem_addr, 32'h20);
    idle(6);
    check_state("R6", 32'h20, 1'b1, 1'b0, 1'b0);

    // R1: hard reset in the middle of a walk
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check_state("R1", 32'h0, 1'b0, 1'b0, 1'b0);
    chk("R1", "mem_req", {31'b0, mem_req}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule